// File: doc/BRIEF.md
# Bit Manipulation Execution Unit

This is a 64-bit functional unit for a processor execution stage. Its operations work on single bits and bit fields and are not general arithmetic. Each cycle it can accept one operation, given as an operation code, two operands and a valid strobe. One clock edge later it presents a 64-bit result, a carry flag, a zero flag and a valid pulse.

The unit supports six operations:

- A field extract. Its start position and length are packed into the low bytes of the second operand.
- An and-not.
- Three operations on the lowest set bit: isolate it, build a mask up to it, and clear it.
- A trailing-zero count, which returns the full operand width when the input is zero.

Decoding, register file access and narrower operand sizes are handled outside the unit.

Top module: `bitops_unit`

## Requirements
- R1: Opcode 0 (field extract): operand B bits [7:0] hold the start index and bits [15:8] hold the length. The result holds A bits start through start+length-1, placed at bit 0, with every higher bit zero. For example, A=0x50, start 4, length 4 gives 0x5.
- R2: Field extract corner cases:
  - A start of 64 or more gives zero.
  - A length of zero gives zero.
  - A field that runs past bit 63 returns only A bits start..63. So a length of 64 or more with start 0 returns A unchanged.
- R3: Opcode 1 (and-not) returns (NOT A) AND B. For example, 0x40 and 0x5D give 0x1D.
- R4: Opcode 2 (isolate lowest) returns only the lowest set bit of A. For example, 0xD0 gives 0x10. A zero input gives zero.
- R5: Opcode 3 (mask to lowest) returns ones in the lowest set bit of A and in every bit below it, for example 0x30 gives 0x1F. A zero input gives all ones.
- R6: Opcode 4 (clear lowest) returns A with its lowest set bit cleared. For example, 0x30 gives 0x20.
- R7: Opcode 5 (trailing-zero count) returns the number of zero bits of A below its lowest set bit. For example, 0x90 gives 4 and 0x1 gives 0. A zero input gives 64.
- R8: Opcodes 6 and 7 return a zero result with the carry flag clear.
- R9: Carry flag:
  - For opcodes 2, 3, 4 and 5, the carry flag is set exactly when A is zero.
  - For opcodes 0 and 1, the carry flag is clear.
- R10: The zero flag is set exactly when the 64-bit result is zero.
- R11: An input accepted with the valid strobe high produces the result, the flags and out_valid in the next cycle. A cycle with the valid strobe low produces out_valid low, and the result and flags keep their previous values.
- R12: A synchronous active-high reset clears out_valid, the result and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation valid strobe |
| in_op | input | 3 | Operation code |
| in_src_a | input | 64 | Operand A (the source) |
| in_src_b | input | 64 | Operand B (the field control or the and-not mask) |
| out_valid | output | 1 | Result valid, one cycle after acceptance |
| out_result | output | 64 | Registered result |
| out_carry | output | 1 | Registered carry flag |
| out_zero | output | 1 | Registered zero flag |

## Verification
The datapath is combinational into a single output register, so a wrong internal value shows up at the ports on the very next cycle.

Some faults would show only for a few inputs:

- An off-by-one in the field mask or the shift corrupts extract results only at the field boundaries.
- A wrong borrow in the lowest-bit logic corrupts results only for zero or single-bit inputs.
- A wrong priority scan in the counter corrupts only the zero input or inputs with the top bit set.

For this reason the stimulus targets those patterns directly and adds a spread of pseudo-random operands. A bad hold of the output register shows up in the first idle cycle after a result.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

    localparam int DATA_W       = 64;
    localparam int CTRL_FIELD_W = 8;
    localparam int OP_W         = 3;

    typedef enum logic [OP_W-1:0] {
        OP_FIELD    = 3'd0,
        OP_ANDNOT   = 3'd1,
        OP_ISOLATE  = 3'd2,
        OP_SMEAR    = 3'd3,
        OP_DROP     = 3'd4,
        OP_TZCOUNT  = 3'd5
    } op_e;

endpackage

// File: rtl/bitops_extract.sv
module bitops_extract #(
    parameter int W     = 64,
    parameter int IDX_W = 8
) (
    input  logic [W-1:0]       src,
    input  logic [2*IDX_W-1:0] ctrl,
    output logic [W-1:0]       res
);
    logic [IDX_W-1:0] start_idx;
    logic [IDX_W-1:0] field_len;
    logic [W-1:0]     shifted;
    logic [W-1:0]     field_mask;

    assign start_idx = ctrl[IDX_W-1:0];
    assign field_len = ctrl[2*IDX_W-1:IDX_W];

    // Shifting by W or more clears the vector, which covers the out-of-range start.
    assign shifted = src >> start_idx;

    // Mask bit g is kept while g is inside the requested length.
    for (genvar g = 0; g < W; g++) begin : g_mask
        assign field_mask[g] = (int'(field_len) > g);
    end

    assign res = shifted & field_mask;

    always_comb begin
        // R2
        len_zero_chk: assert (field_len != '0 || res == '0);
        // R2
        start_range_chk: assert (int'(start_idx) < W || res == '0);
    end

endmodule

// File: rtl/bitops_lowbit.sv
module bitops_lowbit #(
    parameter int W = 64
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] iso,
    output logic [W-1:0] smear,
    output logic [W-1:0] drop,
    output logic         src_zero
);
    logic [W-1:0] x_dec;
    logic [W-1:0] x_neg;

    assign x_dec    = x - W'(1);
    assign x_neg    = '0 - x;
    assign iso      = x & x_neg;
    assign smear    = x ^ x_dec;
    assign drop     = x & x_dec;
    assign src_zero = (x == '0);

    always_comb begin
        // R4
        iso_onehot_chk: assert ($onehot0(iso));
        // R6
        split_chk: assert ((iso | drop) == x);
    end

endmodule

// File: rtl/bitops_tzc.sv
module bitops_tzc #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  x,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (x[i]) cnt = CW'(i);
        end
    end

    always_comb begin
        if (cnt == CW'(W)) begin
            // R7
            empty_chk: assert (x == '0);
        end else begin
            // R7
            hit_chk: assert (x[cnt[CW-2:0]]);
        end
    end

endmodule

// File: rtl/bitops_unit.sv
module bitops_unit
    import bitops_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int IDX_W = CTRL_FIELD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_op,
    input  logic [W-1:0]    in_src_a,
    input  logic [W-1:0]    in_src_b,
    output logic            out_valid,
    output logic [W-1:0]    out_result,
    output logic            out_carry,
    output logic            out_zero
);
    localparam int CW = $clog2(W) + 1;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] result;
        logic         carry;
        logic         zero;
    } stage_s;

    stage_s stage_d, stage_q;

    logic [W-1:0]  fld_res;
    logic [W-1:0]  iso_res;
    logic [W-1:0]  smear_res;
    logic [W-1:0]  drop_res;
    logic          a_zero;
    logic [CW-1:0] tz_cnt;

    bitops_extract #(.W(W), .IDX_W(IDX_W)) u_extract (
        .src  (in_src_a),
        .ctrl (in_src_b[2*IDX_W-1:0]),
        .res  (fld_res)
    );

    bitops_lowbit #(.W(W)) u_lowbit (
        .x        (in_src_a),
        .iso      (iso_res),
        .smear    (smear_res),
        .drop     (drop_res),
        .src_zero (a_zero)
    );

    bitops_tzc #(.W(W), .CW(CW)) u_tzc (
        .x   (in_src_a),
        .cnt (tz_cnt)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.carry = 1'b0;
            case (in_op)
                OP_FIELD:   stage_d.result = fld_res;
                OP_ANDNOT:  stage_d.result = ~in_src_a & in_src_b;
                OP_ISOLATE: begin
                    stage_d.result = iso_res;
                    stage_d.carry  = a_zero;
                end
                OP_SMEAR: begin
                    stage_d.result = smear_res;
                    stage_d.carry  = a_zero;
                end
                OP_DROP: begin
                    stage_d.result = drop_res;
                    stage_d.carry  = a_zero;
                end
                OP_TZCOUNT: begin
                    stage_d.result = {{(W-CW){1'b0}}, tz_cnt};
                    stage_d.carry  = a_zero;
                end
                default:    stage_d.result = '0;
            endcase
            stage_d.zero = (stage_d.result == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign out_valid  = stage_q.valid;
    assign out_result = stage_q.result;
    assign out_carry  = stage_q.carry;
    assign out_zero   = stage_q.zero;

    // R11
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry)));

    // R7
    tz_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_TZCOUNT && in_src_a == '0)
        |=> (out_result == W'(W) && out_carry));

    // R8
    reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op > OP_TZCOUNT) |=> (out_result == '0 && !out_carry && out_zero));

    // R9
    plain_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op == OP_FIELD || in_op == OP_ANDNOT)) |=> !out_carry);

endmodule

// File: tb/bitops_unit_tb.sv
`timescale 1ns/1ps
module bitops_unit_tb;
    localparam int W = 64;

    typedef struct {
        logic [W-1:0] res;
        logic         carry;
        logic         zero;
        string        tag;
    } exp_s;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   in_op = '0;
    logic [W-1:0] in_src_a = '0;
    logic [W-1:0] in_src_b = '0;
    logic         out_valid;
    logic [W-1:0] out_result;
    logic         out_carry;
    logic         out_zero;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;
    exp_s sb_q[$];
    exp_s last_exp;

    always #2 clk = ~clk;

    bitops_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .out_valid(out_valid),
        .out_result(out_result), .out_carry(out_carry), .out_zero(out_zero)
    );

    function automatic int low_index(logic [W-1:0] x);
        for (int k = 0; k < W; k++) if (x[k]) return k;
        return W;
    endfunction

    function automatic exp_s model(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b, string tag);
        exp_s e;
        int   lo;
        int   st;
        int   ln;
        e.res   = '0;
        e.carry = 1'b0;
        e.tag   = tag;
        lo      = low_index(a);
        case (op)
            3'd0: begin
                st = int'(b[7:0]);
                ln = int'(b[15:8]);
                for (int k = 0; k < W; k++)
                    if (k < ln && st + k < W) e.res[k] = a[st + k];
            end
            3'd1: e.res = ~a & b;
            3'd2: begin
                if (lo < W) e.res[lo] = 1'b1;
                e.carry = (lo == W);
            end
            3'd3: begin
                for (int k = 0; k < W; k++) e.res[k] = (k <= lo);
                e.carry = (lo == W);
            end
            3'd4: begin
                e.res = a;
                if (lo < W) e.res[lo] = 1'b0;
                e.carry = (lo == W);
            end
            3'd5: begin
                e.res   = W'(lo);
                e.carry = (lo == W);
            end
            default: e.res = '0;
        endcase
        e.zero = (e.res == '0);
        return e;
    endfunction

    task automatic check_bit(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic check_word(string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic send(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_src_a = a;
        in_src_b = b;
        sb_q.push_back(model(op, a, b, tag));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_op    = 3'd5;
        in_src_a = 64'h1234;
        in_src_b = '1;
    endtask

    // monitor: pop and compare every valid result
    initial begin
        exp_s e;
        forever begin
            @(negedge clk);
            #1;
            if (!rst && out_valid) begin
                if (sb_q.size() == 0) begin
                    check_bit("R11 unexpected out_valid", out_valid, 1'b0);
                end else begin
                    e = sb_q.pop_front();
                    last_exp = e;
                    check_word({e.tag, " result"}, out_result, e.res);
                    check_bit({e.tag, " R9 carry"}, out_carry, e.carry);
                    check_bit({e.tag, " R10 zero"}, out_zero, e.zero);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lfsr_a;
        logic [W-1:0] lfsr_b;
        lfsr_a = 64'hACE1_2468_9BDF_0135;
        lfsr_b = 64'h0F1E_2D3C_4B5A_6978;

        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        check_bit("R12 out_valid after reset", out_valid, 1'b0);
        check_word("R12 result after reset", out_result, '0);
        check_bit("R12 carry after reset", out_carry, 1'b0);
        check_bit("R12 zero after reset", out_zero, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        // R1 field extract
        send(3'd0, 64'h50, 64'h0404, "R1 extract 0x50");
        send(3'd0, 64'hDEAD_BEEF_CAFE_F00D, 64'h1008, "R1 extract mid");
        // R2 extract corners
        send(3'd0, '1, 64'h083C, "R2 extract past top");
        send(3'd0, '1, 64'h0840, "R2 extract start 64");
        send(3'd0, '1, 64'h10C8, "R2 extract start 200");
        send(3'd0, '1, 64'h0005, "R2 extract length 0");
        send(3'd0, 64'h8123_4567_89AB_CDEF, 64'hFF00, "R2 extract full length");
        send(3'd0, 64'h8123_4567_89AB_CDEF, 64'h403F, "R2 extract top bit");
        // R3 and-not
        send(3'd1, 64'h40, 64'h5D, "R3 andnot");
        send(3'd1, '1, '1, "R3 andnot all ones");
        send(3'd1, '0, 64'hFF, "R3 andnot zero a");
        // R4 isolate
        send(3'd2, 64'hD0, '0, "R4 isolate 0xD0");
        send(3'd2, '0, '0, "R4 isolate zero");
        send(3'd2, 64'h8000_0000_0000_0000, '0, "R4 isolate top");
        // R5 mask
        send(3'd3, 64'h30, '0, "R5 mask 0x30");
        send(3'd3, '0, '0, "R5 mask zero");
        send(3'd3, 64'h1, '0, "R5 mask bit0");
        // R6 clear
        send(3'd4, 64'h30, '0, "R6 clear 0x30");
        send(3'd4, 64'h8000_0000_0000_0000, '0, "R6 clear top");
        send(3'd4, '0, '0, "R6 clear zero");
        // R7 trailing zeros
        send(3'd5, 64'h90, '0, "R7 tzc 0x90");
        send(3'd5, 64'h1, '0, "R7 tzc bit0");
        send(3'd5, '0, '0, "R7 tzc zero");
        send(3'd5, 64'h8000_0000_0000_0000, '0, "R7 tzc top");
        // R8 reserved codes
        send(3'd6, '1, '1, "R8 op6");
        send(3'd7, 64'h55, 64'hAA, "R8 op7");

        // pseudo-random burst over all codes
        for (int n = 0; n < 48; n++) begin
            lfsr_a = {lfsr_a[62:0], lfsr_a[63] ^ lfsr_a[62] ^ lfsr_a[60] ^ lfsr_a[59]};
            lfsr_b = {lfsr_b[62:0], lfsr_b[63] ^ lfsr_b[62] ^ lfsr_b[60] ^ lfsr_b[59]};
            send(3'(n % 8), lfsr_a & (n[2] ? lfsr_b : '1), lfsr_b, "R11 random burst");
        end

        // R11 idle cycles: valid drops, result and flags hold
        idle();
        @(negedge clk);
        #1;
        check_bit("R11 out_valid low when idle", out_valid, 1'b0);
        check_word("R11 result held when idle", out_result, last_exp.res);
        check_bit("R11 carry held when idle", out_carry, last_exp.carry);
        check_bit("R11 zero held when idle", out_zero, last_exp.zero);

        // R12 reset mid-stream
        send(3'd3, '0, '0, "R12 pre-reset");
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check_bit("R12 out_valid cleared", out_valid, 1'b0);
        check_word("R12 result cleared", out_result, '0);
        check_bit("R12 carry cleared", out_carry, 1'b0);
        check_bit("R12 zero cleared", out_zero, 1'b0);
        rst = 1'b0;

        repeat (3) @(negedge clk);
        #1;
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R11 results missing: actual=%0d pending expected=0", sb_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule